// File: doc/BRIEF.md
# MDIO Station Management Master

This block is the management side of a two-wire PHY control link. A host hands it one request: read or write, a 5-bit PHY address, a 5-bit register address and, for a write, 16 bits of data. The block then runs one complete management frame on its MDC output and its tri-stateable MDIO line, and reports the end of the frame with a one-clock done pulse. A read returns the 16-bit register value. A read that finds no PHY on the line returns an error flag and no data.

The host request is a valid/ready interface. A request is taken on the rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a host that holds `req_valid` while the block is busy is stalled and that request is not taken. The fields are captured at acceptance and may change afterwards. The response side has no back-pressure: `done`, `err` and `rd_data` are presented for one clock and the host must take them in that cycle. `rd_data` holds its value until the next completion.

MDC is made from the system clock. Each MDC half-period lasts `HALF_DIV` system clocks, so one MDC cycle lasts 2·HALF_DIV clocks. The default of 50 keeps MDC at 2.5 MHz from a 250 MHz clock. The incoming MDIO passes through a `SYNC_STAGES` flop synchronizer. The bits the PHY returns are sampled on the last system clock of each MDC high phase, which allows for that latency.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 MDC cycles in which `mdio_oe` is 1 and `mdio_o` is 1.
- R2: MDC cycles 32 to 35 carry the start pattern 0,1 and then the opcode, with `mdio_oe` high. The opcode is 1,0 for a read (`req_read`=1) and 0,1 for a write.
- R3: MDC cycles 36 to 40 carry `req_phy` from bit 4 down to bit 0. Cycles 41 to 45 carry `req_reg` from bit 4 down to bit 0. `mdio_oe` is high throughout.
- R4: Each MDC low phase and each MDC high phase lasts HALF_DIV clocks. `mdio_o` and `mdio_oe` change only at the falling MDC edge and are stable while MDC is high.
- R5: A write drives 1,0 in cycles 46 and 47, then `req_wdata` from bit 15 down to bit 0 in cycles 48 to 63. It releases MDIO (`mdio_oe`=0) for one final cycle 64, so the frame has 65 MDC cycles in total.
- R6: A read releases MDIO from cycle 46 onward. If `mdio_i` is 0 in cycle 47, bits 15 down to 0 of `rd_data` are taken from cycles 48 to 63. One further released cycle follows, for 65 cycles in total, and `err` is 0.
- R7: A read that finds `mdio_i` at 1 in cycle 47 issues 32 more released cycles, for 80 in total. It ends with `err`=1 together with `done`, and `rd_data`=0.
- R8: A level that the PHY drives on `mdio_i` from the falling MDC edge of a cycle until the next falling edge is the value captured for that cycle.
- R9: `req_ready` (and `busy` as its inverse) shows the idle state. A request presented while `req_ready` is low is not taken, and no frame follows it.
- R10: `done` is a one-clock pulse. It becomes visible 2·HALF_DIV·N clocks after the accepting edge, where N is the number of MDC cycles in the frame. `err` is high only together with `done`, and `rd_data` is 0 after a write.
- R11: While idle, `mdc` and `mdio_oe` are 0. A synchronous `rst` held for one clock returns the block to idle from any point in a frame, with `req_ready` high and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is accepted |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock end-of-frame pulse |
| err | output | 1 | No PHY answered the read; valid with done |
| rd_data | output | 16 | Read result, valid with done |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO line level |

## Verification
Every frame bit is due at a rising MDC edge. The bench checks the driven value and the enable there, and checks both again on every clock of the high phase. Its PHY model changes `mdio_i` half a clock after it sees MDC fall, which is the latest point the capture rule allows. The done pulse is due exactly 2·HALF_DIV·N clocks after the accepting edge, and the bench compares that count with its own clock counter. Done, err and rd_data are sampled on the falling clock edge of that cycle, and the bench confirms that done is gone by the following cycle. The idle checks after a stalled request and after a reset are made on the falling clock edges that follow.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Frame layout in MDC cycles, counted from zero.
  localparam int PRE_BITS    = 32;
  localparam int FRAME_W     = 64;
  localparam int RD_RELEASE  = 46;   // first released cycle of a read
  localparam int TA_BIT      = 47;   // turnaround cycle the PHY drives low
  localparam int DATA_FIRST  = 48;
  localparam int DATA_LAST   = 63;
  localparam int WR_RELEASE  = 64;   // first released cycle of a write
  localparam int NORMAL_LAST = 64;
  localparam int ABORT_BITS  = 32;
  localparam int ABORT_LAST  = TA_BIT + ABORT_BITS;
  localparam int BIT_W       = $clog2(ABORT_LAST + 1);

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy_addr;
    logic [4:0]  reg_addr;
    logic [15:0] wdata;
  } mgmt_req_t;

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic phase_end
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign phase_end = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt) < HALF_DIV)); // R4

endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  mgmt_req_t   req,
  output logic        req_ready,
  input  logic        phase_end,
  input  logic        mdio_s,
  output logic        run,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic        err,
  output logic [15:0] rd_data
);
  logic               busy;
  logic               half_hi;
  logic [BIT_W-1:0]   bitn;
  logic [BIT_W-1:0]   next_bit;
  logic [BIT_W-1:0]   last_bit;
  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] frame;
  logic               is_rd;
  logic               ta_bad;
  logic [15:0]        rdsh;
  logic               in_data;

  assign req_ready = !busy;
  assign run       = busy;
  assign next_bit  = bitn + 1'b1;
  assign in_data   = (int'(bitn) >= DATA_FIRST) && (int'(bitn) <= DATA_LAST);

  // Header, turnaround and data as one word, sent from the top bit down.
  assign frame = {{PRE_BITS{1'b1}}, 2'b01, (req.rd ? 2'b10 : 2'b01),
                  req.phy_addr, req.reg_addr, 2'b10, req.wdata};

  always_ff @(posedge clk) begin
    done <= 1'b0;
    err  <= 1'b0;
    if (rst) begin
      busy     <= 1'b0;
      half_hi  <= 1'b0;
      mdc      <= 1'b0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      bitn     <= '0;
      last_bit <= BIT_W'(NORMAL_LAST);
      shreg    <= '0;
      is_rd    <= 1'b0;
      ta_bad   <= 1'b0;
      rdsh     <= '0;
      rd_data  <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy     <= 1'b1;
        half_hi  <= 1'b0;
        mdc      <= 1'b0;
        bitn     <= '0;
        last_bit <= BIT_W'(NORMAL_LAST);
        is_rd    <= req.rd;
        ta_bad   <= 1'b0;
        mdio_o   <= frame[FRAME_W-1];
        shreg    <= frame << 1;
        mdio_oe  <= 1'b1;
      end
    end else if (phase_end) begin
      if (!half_hi) begin
        mdc     <= 1'b1;
        half_hi <= 1'b1;
      end else begin
        mdc     <= 1'b0;
        half_hi <= 1'b0;
        // Capture at the end of the high phase, after the synchronizer delay.
        if (is_rd && (int'(bitn) == TA_BIT) && mdio_s) begin
          ta_bad   <= 1'b1;
          last_bit <= BIT_W'(ABORT_LAST);
        end
        if (is_rd && !ta_bad && in_data) rdsh <= {rdsh[14:0], mdio_s};
        if (bitn == last_bit) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          done    <= 1'b1;
          err     <= ta_bad;
          rd_data <= (is_rd && !ta_bad) ? rdsh : 16'h0000;
        end else begin
          bitn    <= next_bit;
          mdio_o  <= shreg[FRAME_W-1];
          shreg   <= shreg << 1;
          mdio_oe <= is_rd ? (int'(next_bit) < RD_RELEASE)
                           : (int'(next_bit) < WR_RELEASE);
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err |-> done); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe)); // R11

  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R4

  AST_ACCEPT_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid)); // R9

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && (int'(bitn) >= RD_RELEASE)) |-> !mdio_oe); // R6

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV    = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_read,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mgmt_req_t req;
  logic      phase_end;
  logic      run;
  logic      mdio_s;

  assign req.rd       = req_read;
  assign req.phy_addr = req_phy;
  assign req.reg_addr = req_reg;
  assign req.wdata    = req_wdata;
  assign busy         = run;

  mdio_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .phase_end (phase_end)
  );

  mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (mdio_i),
    .dout (mdio_s)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req       (req),
    .req_ready (req_ready),
    .phase_end (phase_end),
    .mdio_s    (mdio_s),
    .run       (run),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .err       (err),
    .rd_data   (rd_data)
  );

  AST_BUSY_READY: assert property (@(posedge clk) disable iff (rst)
    busy != req_ready); // R9

endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_read = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        mdio_i = 1'b1;
  logic        req_ready, busy, done, err, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_master #(.HALF_DIV(H)) i_mdio_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .busy(busy), .done(done), .err(err),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string region(input int b, input bit rd);
    if (b < 32) return "R1 preamble";
    if (b < 36) return "R2 start/opcode";
    if (b < 46) return "R3 address";
    return rd ? "R6 R7 read tail" : "R5 write tail";
  endfunction

  function automatic bit exp_oe(input int b, input bit rd);
    return rd ? (b < 46) : (b < 64);
  endfunction

  function automatic bit exp_val(input int b, input bit rd, input [4:0] pa,
                                 input [4:0] ra, input [15:0] wd);
    if (b < 32) return 1'b1;
    if (b == 32) return 1'b0;
    if (b == 33) return 1'b1;
    if (b == 34) return rd;
    if (b == 35) return !rd;
    if (b <= 40) return pa[40-b];
    if (b <= 45) return ra[45-b];
    if (b == 46) return 1'b1;
    if (b == 47) return 1'b0;
    if (b <= 63) return wd[63-b];
    return 1'b0;
  endfunction

  function automatic bit phy_bit(input int b, input bit rd, input bit present,
                                 input [15:0] data);
    if (rd && present) begin
      if (b == 47) return 1'b0;
      if (b >= 48 && b <= 63) return data[63-b];
    end
    return 1'b1;
  endfunction

  task automatic run_xact(input bit rd, input [4:0] pa, input [4:0] ra,
                          input [15:0] wd, input bit present, input [15:0] pdata);
    int n;
    int t0;
    bit hi_oe, hi_val;
    n = (rd && !present) ? 80 : 65;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_read = rd; req_phy = pa; req_reg = ra; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    t0 = cyc;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    for (int b = 0; b < n; b++) begin
      @(posedge mdc);
      hi_oe = mdio_oe; hi_val = mdio_o;
      chk(hi_oe == exp_oe(b, rd), {region(b, rd), " enable"}, hi_oe, exp_oe(b, rd));
      if (exp_oe(b, rd))
        chk(hi_val == exp_val(b, rd, pa, ra, wd), {region(b, rd), " value"},
            hi_val, exp_val(b, rd, pa, ra, wd));
      forever begin
        @(negedge clk);
        if (!mdc) break;
        chk(mdio_oe == hi_oe && mdio_o == hi_val, "R4 stable while MDC high",
            {mdio_oe, mdio_o}, {hi_oe, hi_val});
      end
      if (b + 1 < n) mdio_i = phy_bit(b + 1, rd, present, pdata);
    end
    chk(done == 1'b1, "R10 done present", done, 1);
    chk(cyc - t0 == 2 * H * n, "R10 R4 done timing", cyc - t0, 2 * H * n);
    chk(err == (rd && !present), "R7 R10 error flag", err, rd && !present);
    chk(rd_data == ((rd && present) ? pdata : 16'h0000), "R6 R7 R8 read data",
        rd_data, (rd && present) ? pdata : 16'h0000);
    mdio_i = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && err == 1'b0, "R10 done one cycle", {done, err}, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0 && req_ready == 1'b1, "R11 idle after frame",
        {mdc, mdio_oe, req_ready}, 1);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mdc == 0 && mdio_oe == 0 && req_ready == 1 && busy == 0 && done == 0 &&
        err == 0 && rd_data == 0, "R11 reset state",
        {mdc, mdio_oe, req_ready, busy, done, err}, 6'b001000);

    // Directed corners
    run_xact(1'b0, 5'h1f, 5'h1f, 16'hffff, 1'b1, 16'h0000);
    run_xact(1'b0, 5'h00, 5'h00, 16'h0000, 1'b1, 16'h0000);
    run_xact(1'b1, 5'h15, 5'h0a, 16'h1234, 1'b1, 16'ha5c3);
    run_xact(1'b1, 5'h01, 5'h10, 16'h0000, 1'b1, 16'h8001);
    run_xact(1'b1, 5'h0e, 5'h03, 16'h0000, 1'b0, 16'hbeef);
    run_xact(1'b1, 5'h1f, 5'h1f, 16'h0000, 1'b1, 16'hffff);

    // R9: request held while busy is stalled and ignored
    fork
      run_xact(1'b0, 5'h0c, 5'h05, 16'h3c5a, 1'b1, 16'h0000);
      begin
        repeat (40) @(negedge clk);
        req_valid = 1'b1; req_read = 1'b1; req_phy = 5'h11; req_reg = 5'h02;
        req_wdata = 16'h0f0f;
        repeat (10) begin
          @(negedge clk);
          chk(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
        end
        req_valid = 1'b0;
      end
    join
    repeat (4 * H) begin
      @(negedge clk);
      chk(mdc == 1'b0 && req_ready == 1'b1, "R9 stalled request left no frame",
          {mdc, req_ready}, 2'b01);
    end

    // Constrained random mix
    for (int k = 0; k < 24; k++) begin
      bit rd, present;
      rd = $urandom_range(1, 0) == 1;
      present = $urandom_range(4, 0) != 0;
      run_xact(rd, 5'($urandom), 5'($urandom), 16'($urandom), present, 16'($urandom));
    end

    // R11: synchronous reset in mid-frame
    @(negedge clk);
    req_valid = 1'b1; req_read = 1'b0; req_phy = 5'h03; req_reg = 5'h04;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (37) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(mdc == 0 && mdio_oe == 0 && req_ready == 1 && done == 0,
        "R11 reset mid-frame", {mdc, mdio_oe, req_ready, done}, 4'b0010);
    repeat (4 * H) @(negedge clk);
    chk(mdc == 0 && busy == 0, "R11 stays idle after reset", {mdc, busy}, 0);
    run_xact(1'b1, 5'h07, 5'h1c, 16'h0000, 1'b1, 16'h5a96);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule